// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block arbitrates five interrupt sources for a small microcontroller core. The sources are two comparator outputs, two timer overflows and an A/D conversion-complete event. Each source owns a sticky pending flag and an individual enable bit. A master enable gates all five. Flags, enables and the master enable sit in two 8-bit control words. The core reads and writes these words through a simple select/data port.

Acknowledge decisions are taken only in cycles where the core marks its sampling phase with `phase_t2`. At that point the highest-priority source that is both pending and enabled is accepted, provided the master enable is set and a nested acceptance would not overrun a full stack. In the next cycle the block raises `irq_take` for one cycle and presents the source's vector on `irq_vector`. Within the same clock edge it clears the master enable and the serviced flag.

A nesting counter follows the service routines. It counts up on each acknowledge and down on each return strobe. A return-with-reenable sets the master enable again; a plain return leaves it unchanged.

Top module: `prio_irq_ctrl`

## Requirements
- R1: When several sources are pending and enabled at once, the one accepted is the highest in the order comparator 0, comparator 1, timer 0, timer 1, A/D (source index 0 to 4, index 0 highest).
- R2: The vector presented for source index k is VEC_BASE + VEC_STEP*k. With the defaults this gives 04h, 08h, 0Ch, 10h and 14h for indices 0 to 4.
- R3: A source is accepted only when its own enable bit and the master enable are both 1. While either is 0, `irq_take` stays low and the flag stays pending.
- R4: A pending flag is set by a one-cycle pulse on its `src_req` bit. It stays set until its source is accepted or software writes 0 to it.
- R5: Acceptance is evaluated only in a cycle with `phase_t2`=1, using the flags and enables registered before that cycle's edge. A request pulsed in the same cycle as `phase_t2` waits for the next `phase_t2`. `irq_take` and `irq_vector` are valid in the cycle after the accepting `phase_t2` cycle.
- R6: While `in_service` is 1 and `stack_full` is 1, no further acceptance happens. Once software has set the master enable and `stack_full` is 0, a nested acceptance is allowed. `in_service` is 1 while at least one acceptance has not been matched by a return strobe.
- R7: At the accepting edge the master enable and the accepted source's flag are both cleared.
- R8: `ret_reen` sets the master enable. `ret_plain` leaves it unchanged. Either strobe ends one nesting level.
- R9: Word 0 (`reg_*_sel`=0) holds master enable at bit 0, the enables of comparator 0, comparator 1 and timer 0 at bits 1, 2 and 3, and their flags at bits 4, 5 and 6. Word 1 holds the timer 1 and A/D enables at bits 0 and 1 and their flags at bits 4 and 5. All other bits read 0, and everything resets to 0.
- R10: Writing 1 to a flag bit makes that source pending exactly as a hardware request would.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phase_t2 | input | 1 | One-cycle marker of the instruction sampling phase |
| src_req | input | 5 | Request pulses, index 0 comparator 0 .. index 4 A/D |
| stack_full | input | 1 | Core stack has no free entry |
| ret_plain | input | 1 | Plain return strobe |
| ret_reen | input | 1 | Return-with-reenable strobe |
| reg_wr_en | input | 1 | Control word write strobe |
| reg_wr_sel | input | 1 | Control word selected for writing |
| reg_wr_data | input | 8 | Write data |
| reg_rd_sel | input | 1 | Control word selected for reading |
| reg_rd_data | output | 8 | Read data (combinational) |
| irq_take | output | 1 | One-cycle acknowledge to the core |
| irq_vector | output | VEC_W | Vector address of the accepted source |
| in_service | output | 1 | At least one service routine is open |

## Verification
The assertions assume that `phase_t2`, `src_req`, the return strobes and register writes are single-cycle pulses. They also assume that `ret_plain` and `ret_reen` are never asserted together and never fall in the cycle of an acknowledge. The stimulus changes every input on the falling edge and issues one event per task. Each return is therefore applied only after the matching `irq_take` cycle has ended, and writes never coincide with `phase_t2`. The scoreboard queues an expected vector before each `phase_t2` pulse that should be accepted. Any acknowledge without a queued vector is reported.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   localparam int unsigned SRC_N   = 5;
   localparam int unsigned REG_W   = 8;
   localparam int unsigned EMI_BIT = 0;
   // Per-source placement in the two control words.
   localparam int unsigned SRC_REG  [SRC_N] = '{0, 0, 0, 1, 1};
   localparam int unsigned SRC_EN   [SRC_N] = '{1, 2, 3, 0, 1};
   localparam int unsigned SRC_FLAG [SRC_N] = '{4, 5, 6, 4, 5};

   typedef enum logic [2:0] {
      SRC_CMP0 = 3'd0,
      SRC_CMP1 = 3'd1,
      SRC_TMR0 = 3'd2,
      SRC_TMR1 = 3'd3,
      SRC_ADC  = 3'd4
   } irq_src_e;
endpackage

// File: rtl/irqc_ctrl_regs.sv
module irqc_ctrl_regs
   import irqc_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             wr_sel,
   input  logic [REG_W-1:0] wr_data,
   input  logic             rd_sel,
   output logic [REG_W-1:0] rd_data,
   input  logic [SRC_N-1:0] hw_set,
   input  logic [SRC_N-1:0] svc_clr,
   input  logic             svc_take,
   input  logic             reti,
   output logic [SRC_N-1:0] flag_q,
   output logic [SRC_N-1:0] en_q,
   output logic             emi_q
);
   logic [SRC_N-1:0] flag_d;
   logic [SRC_N-1:0] en_d;
   logic [SRC_N-1:0] hit;
   logic             emi_d;
   logic             wr_word0;

   assign wr_word0 = wr_en && !wr_sel;

   for (genvar i = 0; i < SRC_N; i++) begin : g_src
      assign hit[i]    = wr_en && (wr_sel == (SRC_REG[i] != 0));
      // hardware set wins over acceptance clear, which wins over software write
      assign flag_d[i] = hw_set[i] |
                         (~svc_clr[i] & (hit[i] ? wr_data[SRC_FLAG[i]] : flag_q[i]));
      assign en_d[i]   = hit[i] ? wr_data[SRC_EN[i]] : en_q[i];

      AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
         flag_q[i] && !svc_clr[i] && !hit[i] |=> flag_q[i]); // R4
      AST_HW_SET: assert property (@(posedge clk) disable iff (!rst_n)
         hw_set[i] |=> flag_q[i]); // R4
   end

   always_comb begin
      if (svc_take)      emi_d = 1'b0;
      else if (reti)     emi_d = 1'b1;
      else if (wr_word0) emi_d = wr_data[EMI_BIT];
      else               emi_d = emi_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_q <= '0;
         en_q   <= '0;
         emi_q  <= 1'b0;
      end else begin
         flag_q <= flag_d;
         en_q   <= en_d;
         emi_q  <= emi_d;
      end
   end

   always_comb begin
      rd_data = '0;
      if (!rd_sel) rd_data[EMI_BIT] = emi_q;
      for (int i = 0; i < SRC_N; i++) begin
         if ((SRC_REG[i] != 0) == rd_sel) begin
            rd_data[SRC_FLAG[i]] = flag_q[i];
            rd_data[SRC_EN[i]]   = en_q[i];
         end
      end
   end

   AST_TAKE_DROPS_EMI: assert property (@(posedge clk) disable iff (!rst_n)
      svc_take |=> !emi_q); // R7
   AST_RETI_RAISES_EMI: assert property (@(posedge clk) disable iff (!rst_n)
      reti && !svc_take |=> emi_q); // R8
endmodule

// File: rtl/irqc_prio_pick.sv
module irqc_prio_pick #(
   parameter int unsigned N     = 5,
   parameter int unsigned STYLE = 0,
   localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     cand,
   output logic [N-1:0]     grant,
   output logic [IDX_W-1:0] idx,
   output logic             any
);
   if (STYLE > 1) begin : g_bad_style
      $error("irqc_prio_pick: STYLE must be 0 or 1");
   end

   if (STYLE == 0) begin : g_scan
      // walk from lowest priority upward so index 0 overrides all
      always_comb begin
         grant = '0;
         for (int i = N - 1; i >= 0; i--) begin
            if (cand[i]) grant = N'(1) << i;
         end
      end
   end else begin : g_isolate
      // two's-complement trick isolates the lowest set bit
      assign grant = cand & (~cand + N'(1));
   end

   assign any = |cand;

   always_comb begin
      idx = '0;
      for (int i = 0; i < N; i++) begin
         if (grant[i]) idx = IDX_W'(i);
      end
   end
endmodule

// File: rtl/irqc_svc_track.sv
module irqc_svc_track #(
   parameter int unsigned NEST_W = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic take,
   input  logic ret_any,
   output logic in_service
);
   if (NEST_W < 1) begin : g_bad_width
      $error("irqc_svc_track: NEST_W must be at least 1");
   end

   logic [NEST_W-1:0] depth_q;
   logic              inc;
   logic              dec;

   assign inc = take && !(&depth_q);
   assign dec = ret_any && (depth_q != '0);

   always_ff @(posedge clk) begin
      if (!rst_n)          depth_q <= '0;
      else if (inc && !dec) depth_q <= depth_q + 1'b1;
      else if (dec && !inc) depth_q <= depth_q - 1'b1;
   end

   assign in_service = (depth_q != '0);

   AST_TAKE_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
      take && !ret_any |=> in_service); // R6
   AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
      !in_service && !take |=> !in_service); // R6
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
   import irqc_pkg::*;
#(
   parameter int unsigned VEC_W     = 8,
   parameter int unsigned VEC_BASE  = 4,
   parameter int unsigned VEC_STEP  = 4,
   parameter int unsigned NEST_W    = 3,
   parameter int unsigned ARB_STYLE = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             phase_t2,
   input  logic [4:0]       src_req,
   input  logic             stack_full,
   input  logic             ret_plain,
   input  logic             ret_reen,
   input  logic             reg_wr_en,
   input  logic             reg_wr_sel,
   input  logic [7:0]       reg_wr_data,
   input  logic             reg_rd_sel,
   output logic [7:0]       reg_rd_data,
   output logic             irq_take,
   output logic [VEC_W-1:0] irq_vector,
   output logic             in_service
);
   localparam int unsigned IDX_W   = $clog2(SRC_N);
   localparam int unsigned VEC_TOP = VEC_BASE + VEC_STEP * (SRC_N - 1);

   if (VEC_TOP >= (1 << VEC_W)) begin : g_bad_vec
      $error("prio_irq_ctrl: highest vector does not fit in VEC_W");
   end
   if (VEC_STEP == 0) begin : g_bad_step
      $error("prio_irq_ctrl: VEC_STEP must be non-zero");
   end

   logic [SRC_N-1:0] flag_q, en_q, cand, grant, svc_clr;
   logic [IDX_W-1:0] idx;
   logic             any, emi_q, ack_now;
   logic             take_q;
   logic [VEC_W-1:0] vec_q;

   assign cand    = flag_q & en_q;
   assign ack_now = phase_t2 && emi_q && any && !(in_service && stack_full);
   assign svc_clr = ack_now ? grant : '0;

   irqc_ctrl_regs u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (reg_wr_en),
      .wr_sel   (reg_wr_sel),
      .wr_data  (reg_wr_data),
      .rd_sel   (reg_rd_sel),
      .rd_data  (reg_rd_data),
      .hw_set   (src_req),
      .svc_clr  (svc_clr),
      .svc_take (ack_now),
      .reti     (ret_reen),
      .flag_q   (flag_q),
      .en_q     (en_q),
      .emi_q    (emi_q)
   );

   irqc_prio_pick #(.N(SRC_N), .STYLE(ARB_STYLE)) u_pick (
      .cand  (cand),
      .grant (grant),
      .idx   (idx),
      .any   (any)
   );

   irqc_svc_track #(.NEST_W(NEST_W)) u_svc (
      .clk        (clk),
      .rst_n      (rst_n),
      .take       (ack_now),
      .ret_any    (ret_plain || ret_reen),
      .in_service (in_service)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         take_q <= 1'b0;
         vec_q  <= '0;
      end else begin
         take_q <= ack_now;
         if (ack_now) vec_q <= VEC_W'(VEC_BASE + VEC_STEP * int'(idx));
      end
   end

   assign irq_take   = take_q;
   assign irq_vector = vec_q;

   AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant)); // R1
   AST_VEC_GRID: assert property (@(posedge clk) disable iff (!rst_n)
      irq_take |-> ((irq_vector >= VEC_W'(VEC_BASE)) &&
                    (((irq_vector - VEC_W'(VEC_BASE)) % VEC_W'(VEC_STEP)) == 0))); // R2
   AST_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      phase_t2 && !emi_q |=> !irq_take); // R3
   AST_TAKE_ON_T2: assert property (@(posedge clk) disable iff (!rst_n)
      irq_take |-> $past(phase_t2)); // R5
   AST_NO_NEST_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      phase_t2 && in_service && stack_full |=> !irq_take); // R6
   AST_RET_KEEPS_EMI: assert property (@(posedge clk) disable iff (!rst_n)
      ret_plain && !ret_reen && !ack_now && !(reg_wr_en && !reg_wr_sel)
      |=> emi_q == $past(emi_q)); // R8
endmodule

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       phase_t2, stack_full, ret_plain, ret_reen;
   logic [4:0] src_req;
   logic       reg_wr_en, reg_wr_sel, reg_rd_sel;
   logic [7:0] reg_wr_data, reg_rd_data, irq_vector;
   logic       irq_take, in_service;

   int   checks = 0;
   int   errs   = 0;
   bit   done   = 1'b0;
   logic [7:0] exp_q[$];

   always #(CLK_PERIOD / 2) clk = ~clk;

   prio_irq_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .phase_t2(phase_t2), .src_req(src_req),
      .stack_full(stack_full), .ret_plain(ret_plain), .ret_reen(ret_reen),
      .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
      .reg_rd_sel(reg_rd_sel), .reg_rd_data(reg_rd_data),
      .irq_take(irq_take), .irq_vector(irq_vector), .in_service(in_service)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   // monitor: every acknowledge must match the head of the scoreboard
   always @(negedge clk) begin
      if (rst_n && irq_take) begin
         checks++;
         if (exp_q.size() == 0) begin
            errs++;
            $display("FAIL R3/R5/R6 unexpected take: act=%0h exp=none", irq_vector);
         end else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            if (irq_vector !== e) begin
               errs++;
               $display("FAIL R1/R2 vector: act=%0h exp=%0h", irq_vector, e);
            end
         end
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic sel, input logic [7:0] d);
      reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = d;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic rd(input logic sel, input logic [7:0] e, input string tag);
      reg_rd_sel = sel;
      #1;
      chk(tag, reg_rd_data, e);
   endtask

   task automatic req(input logic [4:0] m);
      src_req = m;
      @(negedge clk);
      src_req = '0;
   endtask

   task automatic t2(input logic [7:0] expect_vec, input bit expect_take);
      if (expect_take) exp_q.push_back(expect_vec);
      phase_t2 = 1'b1;
      @(negedge clk);
      phase_t2 = 1'b0;
      @(negedge clk);
   endtask

   task automatic reti();
      ret_reen = 1'b1;
      @(negedge clk);
      ret_reen = 1'b0;
   endtask

   task automatic retp();
      ret_plain = 1'b1;
      @(negedge clk);
      ret_plain = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errs++;
         checks++;
         $display("FAIL R5 watchdog: act=hung exp=finished");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; phase_t2 = 1'b0; stack_full = 1'b0; ret_plain = 1'b0;
      ret_reen = 1'b0; src_req = '0; reg_wr_en = 1'b0; reg_wr_sel = 1'b0;
      reg_wr_data = '0; reg_rd_sel = 1'b0;
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R9 reset state
      rd(0, 8'h00, "R9 reset word0");
      rd(1, 8'h00, "R9 reset word1");
      chk("R9 reset take", irq_take, 0);
      chk("R9 reset in_service", in_service, 0);

      // R9 layout of enables
      wr(0, 8'h0F); wr(1, 8'h03);
      rd(0, 8'h0F, "R9 word0 enables");
      rd(1, 8'h03, "R9 word1 enables");

      // R4/R9 all five pending; R5 nothing taken without phase_t2
      req(5'h1F);
      rd(0, 8'h7F, "R9 word0 flags");
      rd(1, 8'h33, "R9 word1 flags");
      idle(3);
      chk("R5 no take between phases", irq_take, 0);

      // R1/R7 highest first, EMI and its flag cleared
      t2(8'h04, 1);
      rd(0, 8'h6E, "R7 emi and cmp0 flag cleared");
      chk("R6 in_service after take", in_service, 1);
      // R3 master enable clear masks the rest
      t2(8'h00, 0);
      rd(0, 8'h6E, "R3 pending held while masked");
      reti();
      rd(0, 8'h6F, "R8 reti sets emi");
      chk("R8 reti closes level", in_service, 0);

      // R1/R2 remaining order
      t2(8'h08, 1); reti();
      t2(8'h0C, 1); reti();
      t2(8'h10, 1); reti();
      t2(8'h14, 1); reti();
      rd(0, 8'h0F, "R1 all word0 flags served");
      rd(1, 8'h03, "R1 all word1 flags served");

      // R8 plain return keeps emi low
      req(5'h04);
      t2(8'h0C, 1);
      retp();
      rd(0, 8'h0E, "R8 plain return leaves emi");
      chk("R8 plain return closes level", in_service, 0);

      // R10 software-set flag is a request
      wr(1, 8'h13);
      wr(0, 8'h0F);
      t2(8'h10, 1);
      rd(1, 8'h03, "R10 soft flag served");
      reti();

      // R3 individual enable off: stays pending; R4 software clear
      wr(0, 8'h0D);
      req(5'h01);
      t2(8'h00, 0);
      rd(0, 8'h1D, "R3 disabled source pending");
      wr(0, 8'h0D);
      rd(0, 8'h0D, "R4 software clears flag");

      // R3 master enable off with source enabled, then released
      wr(0, 8'h0E);
      req(5'h01);
      t2(8'h00, 0);
      rd(0, 8'h1E, "R3 emi off masks");
      wr(0, 8'h1F);
      t2(8'h04, 1);
      reti();

      // R5 request in the same cycle as phase_t2 waits one phase
      src_req = 5'h01; phase_t2 = 1'b1;
      @(negedge clk);
      src_req = '0; phase_t2 = 1'b0;
      @(negedge clk);
      chk("R5 same-cycle request deferred", in_service, 0);
      t2(8'h04, 1);
      reti();

      // R6 nesting blocked by full stack, allowed once it frees
      wr(0, 8'h0F);
      req(5'h04);
      t2(8'h0C, 1);
      stack_full = 1'b1;
      wr(0, 8'h0F);
      req(5'h01);
      t2(8'h00, 0);
      rd(0, 8'h1F, "R6 nested held while stack full");
      stack_full = 1'b0;
      t2(8'h04, 1);
      rd(0, 8'h0E, "R6 nested taken");
      reti();
      chk("R6 one level still open", in_service, 1);
      rd(0, 8'h0F, "R8 inner reti sets emi");
      reti();
      chk("R6 all levels closed", in_service, 0);

      idle(2);
      chk("R5 scoreboard drained", exp_q.size(), 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule